// File: doc/BRIEF.md
# Multi-Engine Match Result Scheduler

This block sits behind three string-matching engines and turns their match reports into streams of string identifiers. Each report names the engine that saw the match and the address of a match list in an external match-number memory. Reports wait in a shared queue and are served one at a time, oldest first.

For the report at the head of the queue, the block reads consecutive memory words, starting at the report's address. Every word yields one output beat. The beat carries both 13-bit string numbers of the word, the word's end flag and the engine number of the report. Reading stops after the word whose end flag is set, and the next queued report then starts. The memory answers one cycle after a read request. While a list is being read, one word is fetched per cycle.

Top module: `match_sched`

## Requirements
- R1: A memory word is 27 bits wide. Bits [12:0] hold the first string number, bits [25:13] the second, and bit 26 is the end-of-list flag. Each word read produces one beat with `out_valid_o` high. The beat has `out_id0_o` equal to bits [12:0], `out_id1_o` equal to bits [25:13] and `out_last_o` equal to bit 26. Both numbers are always output.
- R2: A list is read from its start address upward, one address per word, until a word with the end flag has been emitted. A list whose first word has the end flag set produces exactly one beat.
- R3: Every beat carries, on `out_engine_o`, the index (0, 1 or 2) of the engine whose report started the list.
- R4: Reports are served in arrival order. Reports arriving in the same cycle are queued in ascending engine index.
- R5: The beats of one list are never interleaved with those of another. A report's address goes to the memory only once that report heads the queue, and only after the previous list's end word has arrived.
- R6: `mem_data_i` is taken as the answer to the read requested one cycle earlier. The matching beat appears on the outputs one cycle after that.
- R7: The queue holds 8 reports. `full_o` is high exactly while 8 reports are waiting.
- R8: A report that finds no free queue slot, counted before any removal in the same cycle, is dropped. It sets `overflow_o`, which stays high until reset. Reports from lower engine indices in the same cycle take the remaining slots first.
- R9: After reset, `out_valid_o`, `mem_rd_o`, `full_o` and `overflow_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rep_valid_i | input | 3 | Match report strobe, one bit per engine |
| rep_addr_i | input | 33 | Match-list start addresses; engine i uses bits [11*i+10:11*i] |
| mem_rd_o | output | 1 | Read request to the match-number memory |
| mem_addr_o | output | 11 | Read address |
| mem_data_i | input | 27 | Read data, one cycle after the request |
| out_valid_o | output | 1 | Output beat valid |
| out_engine_o | output | 2 | Engine index of the current list |
| out_id0_o | output | 13 | First string number of the word |
| out_id1_o | output | 13 | Second string number of the word |
| out_last_o | output | 1 | End-of-list flag of the word |
| full_o | output | 1 | Queue holds 8 reports |
| overflow_o | output | 1 | Sticky: a report was dropped |

## Verification
A corrupted queue pointer or slot index shows up at the ports as a beat carrying the wrong engine number or string numbers. This is visible at the first beat of the affected list, at most a few cycles after the report is dequeued. A wrong address step or a missed end flag shows up within one beat, either as string numbers from the wrong word or as a list running past its end into the next one. A wrong queue count shows up as `full_o` at the wrong moment, as a dropped report once eight are waiting, or as a report that never produces beats.

// File: rtl/match_sched_pkg.sv
package match_sched_pkg;
  typedef enum logic {
    RD_IDLE = 1'b0,
    RD_WAIT = 1'b1
  } rd_state_e;
endpackage

// File: rtl/match_fifo.sv
module match_fifo #(
  parameter int N_ENG  = 3,
  parameter int ENG_W  = 2,
  parameter int ADDR_W = 11,
  parameter int DEPTH  = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_ENG-1:0]        push_i,
  input  logic [N_ENG*ADDR_W-1:0] addr_i,
  input  logic                    pop_i,
  output logic [ENG_W-1:0]        head_eng_o,
  output logic [ADDR_W-1:0]       head_addr_o,
  output logic                    empty_o,
  output logic [$clog2(DEPTH):0]  count_o,
  output logic                    drop_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam int ENT_W = ENG_W + ADDR_W;

  logic [ENT_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q, free, n_acc;
  logic [N_ENG-1:0] acc;
  logic [PTR_W-1:0] slot [N_ENG];

  // ascending engine index claims free slots first
  always_comb begin
    free   = CNT_W'(DEPTH) - cnt_q;
    n_acc  = '0;
    drop_o = 1'b0;
    for (int i = 0; i < N_ENG; i++) begin
      acc[i]  = 1'b0;
      slot[i] = wr_q + n_acc[PTR_W-1:0];
      if (push_i[i]) begin
        if (n_acc < free) begin
          acc[i] = 1'b1;
          n_acc  = n_acc + CNT_W'(1);
        end else begin
          drop_o = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < N_ENG; i++) begin
      if (acc[i]) mem_q[slot[i]] <= {ENG_W'(i), addr_i[i*ADDR_W +: ADDR_W]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_q + n_acc[PTR_W-1:0];
      rd_q  <= rd_q + PTR_W'(pop_i);
      cnt_q <= cnt_q + n_acc - CNT_W'(pop_i);
    end
  end

  assign {head_eng_o, head_addr_o} = mem_q[rd_q];
  assign empty_o = (cnt_q == '0);
  assign count_o = cnt_q;
endmodule

// File: rtl/list_reader.sv
module list_reader
  import match_sched_pkg::*;
#(
  parameter int ENG_W  = 2,
  parameter int ADDR_W = 11,
  parameter int ID_W   = 13
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                avail_i,
  input  logic [ENG_W-1:0]    head_eng_i,
  input  logic [ADDR_W-1:0]   head_addr_i,
  output logic                pop_o,
  output logic                mem_rd_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  input  logic [2*ID_W:0]     mem_data_i,
  output logic                out_valid_o,
  output logic [ENG_W-1:0]    out_engine_o,
  output logic [ID_W-1:0]     out_id0_o,
  output logic [ID_W-1:0]     out_id1_o,
  output logic                out_last_o
);
  localparam int LAST_B = 2 * ID_W;

  rd_state_e         st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ENG_W-1:0]  eng_q;
  logic              data_last, step;

  assign data_last  = mem_data_i[LAST_B];
  assign step       = (st_q == RD_WAIT) && !data_last;
  assign pop_o      = !step && avail_i;
  assign mem_rd_o   = step || pop_o;
  assign mem_addr_o = step ? addr_q + ADDR_W'(1) : head_addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= RD_IDLE;
      addr_q      <= '0;
      eng_q       <= '0;
      out_valid_o <= 1'b0;
      out_engine_o <= '0;
      out_id0_o   <= '0;
      out_id1_o   <= '0;
      out_last_o  <= 1'b0;
    end else begin
      st_q        <= mem_rd_o ? RD_WAIT : RD_IDLE;
      out_valid_o <= (st_q == RD_WAIT);
      if (mem_rd_o) addr_q <= mem_addr_o;
      if (pop_o)    eng_q  <= head_eng_i;
      if (st_q == RD_WAIT) begin
        out_engine_o <= eng_q;
        out_id0_o    <= mem_data_i[ID_W-1:0];
        out_id1_o    <= mem_data_i[2*ID_W-1:ID_W];
        out_last_o   <= data_last;
      end
    end
  end
endmodule

// File: rtl/match_sched.sv
module match_sched #(
  parameter int N_ENG     = 3,
  parameter int MEM_WORDS = 2048,
  parameter int ID_W      = 13,
  parameter int DEPTH     = 8
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [N_ENG-1:0]                    rep_valid_i,
  input  logic [N_ENG*$clog2(MEM_WORDS)-1:0]  rep_addr_i,
  output logic                                mem_rd_o,
  output logic [$clog2(MEM_WORDS)-1:0]        mem_addr_o,
  input  logic [2*ID_W:0]                     mem_data_i,
  output logic                                out_valid_o,
  output logic [$clog2(N_ENG)-1:0]            out_engine_o,
  output logic [ID_W-1:0]                     out_id0_o,
  output logic [ID_W-1:0]                     out_id1_o,
  output logic                                out_last_o,
  output logic                                full_o,
  output logic                                overflow_o
);
  localparam int ADDR_W = $clog2(MEM_WORDS);
  localparam int ENG_W  = $clog2(N_ENG);
  localparam int CNT_W  = $clog2(DEPTH) + 1;

  logic              pop, empty, drop;
  logic [ENG_W-1:0]  head_eng;
  logic [ADDR_W-1:0] head_addr;
  logic [CNT_W-1:0]  fifo_cnt;

  match_fifo #(.N_ENG(N_ENG), .ENG_W(ENG_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(rep_valid_i), .addr_i(rep_addr_i), .pop_i(pop),
    .head_eng_o(head_eng), .head_addr_o(head_addr),
    .empty_o(empty), .count_o(fifo_cnt), .drop_o(drop)
  );

  list_reader #(.ENG_W(ENG_W), .ADDR_W(ADDR_W), .ID_W(ID_W)) u_rd (
    .clk_i, .rst_ni,
    .avail_i(!empty), .head_eng_i(head_eng), .head_addr_i(head_addr),
    .pop_o(pop), .mem_rd_o, .mem_addr_o, .mem_data_i,
    .out_valid_o, .out_engine_o, .out_id0_o, .out_id1_o, .out_last_o
  );

  assign full_o = (fifo_cnt == CNT_W'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   overflow_o <= 1'b0;
    else if (drop) overflow_o <= 1'b1;
  end
endmodule

// File: rtl/match_sched_chk.sv
module match_sched_chk #(
  parameter int N_ENG  = 3,
  parameter int ADDR_W = 11,
  parameter int ID_W   = 13,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_ENG-1:0]  rep_valid_i,
  input logic              mem_rd_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [2*ID_W:0]   mem_data_i,
  input logic              out_valid_o,
  input logic [$clog2(N_ENG)-1:0] out_engine_o,
  input logic              full_o,
  input logic              overflow_o,
  input logic [CNT_W-1:0]  fifo_cnt
);
  assert_beat_after_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(mem_rd_o, 2));

  assert_addr_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o && $past(mem_rd_o) && !mem_data_i[2*ID_W]) |-> mem_addr_o == $past(mem_addr_o) + 1'b1);

  assert_engine_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> out_engine_o < N_ENG);

  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && |rep_valid_i) |=> overflow_o);

  assert_overflow_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);

  assert_count_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt <= CNT_W'(DEPTH));
endmodule

bind match_sched match_sched_chk #(
  .N_ENG(N_ENG), .ADDR_W(ADDR_W), .ID_W(ID_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rep_valid_i(rep_valid_i),
  .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .mem_data_i(mem_data_i),
  .out_valid_o(out_valid_o), .out_engine_o(out_engine_o),
  .full_o(full_o), .overflow_o(overflow_o), .fifo_cnt(fifo_cnt)
);

// File: tb/tb_match_sched.sv
module tb_match_sched;
  localparam int AW = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    rep_valid = '0;
  logic [3*AW-1:0] rep_addr = '0;
  logic          mem_rd;
  logic [AW-1:0] mem_addr;
  logic [26:0]   mem_data = '0;
  logic          out_valid, out_last, full, overflow;
  logic [1:0]    out_engine;
  logic [12:0]   out_id0, out_id1;

  int checks = 0, errs = 0;
  int ev_q[$];
  bit cur_active = 0;
  int cur_addr, cur_eng;

  always #5 clk = ~clk;

  match_sched dut (
    .clk_i(clk), .rst_ni(rst_n), .rep_valid_i(rep_valid), .rep_addr_i(rep_addr),
    .mem_rd_o(mem_rd), .mem_addr_o(mem_addr), .mem_data_i(mem_data),
    .out_valid_o(out_valid), .out_engine_o(out_engine), .out_id0_o(out_id0),
    .out_id1_o(out_id1), .out_last_o(out_last), .full_o(full), .overflow_o(overflow)
  );

  function automatic bit last_f(int w);
    if (w >= 1024) return (w % 64) == 63;
    return ((w * 7) % 5 == 0) || (w % 8 == 7);
  endfunction

  function automatic logic [26:0] word_f(int w);
    logic [12:0] a, b;
    a = 13'((w * 37 + 5) % 8192);
    b = 13'((w * 101 + 17) % 8192);
    return {last_f(w), b, a};
  endfunction

  // memory model: one-cycle read latency (R6)
  always @(posedge clk) if (mem_rd) mem_data <= word_f(int'(mem_addr));

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // beat checker, sampled at negedge
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (!cur_active) begin
        if (ev_q.size() == 0) begin
          chk(0, "R5 unexpected beat", 1, 0);
        end else begin
          int e;
          e = ev_q.pop_front();
          cur_eng = e >> AW;
          cur_addr = e & ((1 << AW) - 1);
          cur_active = 1;
        end
      end
      if (cur_active) begin
        logic [26:0] w;
        w = word_f(cur_addr);
        chk(out_id0 == w[12:0], "R1 id0", int'(out_id0), int'(w[12:0]));
        chk(out_id1 == w[25:13], "R1 id1", int'(out_id1), int'(w[25:13]));
        chk(out_last == w[26], "R2 last flag", int'(out_last), int'(w[26]));
        chk(int'(out_engine) == cur_eng, "R3 R4 engine", int'(out_engine), cur_eng);
        if (w[26]) cur_active = 0;
        else cur_addr = (cur_addr + 1) % 2048;
      end
    end
  end

  // drive one cycle of reports; acc marks reports expected to be queued
  task automatic drive(logic [2:0] m, int a0, int a1, int a2, logic [2:0] acc);
    int a[3];
    a[0] = a0; a[1] = a1; a[2] = a2;
    @(negedge clk);
    rep_valid = m;
    for (int i = 0; i < 3; i++) begin
      rep_addr[i*AW +: AW] = AW'(a[i]);
      if (acc[i]) ev_q.push_back((i << AW) | a[i]);
    end
    @(negedge clk);
    rep_valid = '0;
  endtask

  task automatic drain();
    while (ev_q.size() != 0 || cur_active) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    chk(!out_valid, "R9 out_valid reset", int'(out_valid), 0);
    chk(!mem_rd, "R9 mem_rd reset", int'(mem_rd), 0);
    chk(!full, "R9 full reset", int'(full), 0);
    chk(!overflow, "R9 overflow reset", int'(overflow), 0);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL R5 watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    do_reset();

    // R2: single-word list gives one beat
    drive(3'b001, 0, 0, 0, 3'b001);
    drain();
    // R4: same-cycle reports in ascending engine order
    drive(3'b101, 8, 0, 16, 3'b101);
    drive(3'b110, 0, 40, 3, 3'b110);
    drain();
    chk(!overflow, "R8 no overflow yet", int'(overflow), 0);

    // R7/R8: fill the queue behind a long list, drop the last report
    drive(3'b001, 1024, 0, 0, 3'b001);
    @(negedge clk);
    drive(3'b111, 100, 200, 300, 3'b111);
    drive(3'b111, 9, 17, 25, 3'b111);
    drive(3'b111, 50, 60, 70, 3'b011);
    chk(full, "R7 full at 8", int'(full), 1);
    chk(overflow, "R8 overflow set on drop", int'(overflow), 1);
    drain();
    chk(!full, "R7 full clears", int'(full), 0);
    chk(overflow, "R8 overflow sticky", int'(overflow), 1);
    do_reset();

    // random bursts, never more than 6 queued
    for (int it = 0; it < 60; it++) begin
      int nb;
      nb = 1 + int'($urandom % 2);
      for (int b = 0; b < nb; b++) begin
        logic [2:0] m;
        m = 3'($urandom % 7 + 1);
        drive(m, int'($urandom % 1000), int'($urandom % 1000), int'($urandom % 1000), m);
      end
      drain();
    end
    chk(!overflow, "R8 no drop in random phase", int'(overflow), 0);
    chk(ev_q.size() == 0 && !cur_active, "R5 all lists completed", ev_q.size(), 0);
    summary();
    $finish;
  end
endmodule